// File: doc/BRIEF.md
# Serial LED Status Shifter

This block lights a bank of status LEDs through an external chain of serial-in, parallel-out shift registers, using only three pins: a serial clock, a serial data line and a latch strobe. It repeats the same cycle for as long as software keeps it enabled. First it waits for an idle gap. Then it captures the current LED states. It shifts out a framed sequence and finally pulses the latch, so that every LED in the chain changes at the same moment.

A frame holds the following bits in order:

- a start bit,
- two leading pad bits,
- twelve LED bits, LED 1 first,
- two trailing pad bits.

A media select chooses one of two pre-decoded twelve-bit LED vectors, one for fiber and one for copper. A polarity mode lets the same frame drive chains whose LEDs light on a low level. The status-to-LED decode and any blinking are done upstream. While the enable input is low, the block and its pins stay in their reset state.

Top module: `led_chain_driver`

## Requirements
- R1: After `rst`, and for as long as `soft_en` has been low, `led_sclk`, `led_sdata` and `led_latch` are all low and the block does not start a frame.
- R2: If `soft_en` drops at any time, including in the middle of a frame, all three outputs are low one clock later and stay low. Raising `soft_en` again starts a new, complete frame.
- R3: `led_sclk` is high for exactly `HALF_DIV` system clocks in each serial period. `led_sdata` changes only while `led_sclk` is low, so it changes at a falling edge and is stable across each rising edge.
- R4: A frame has 17 serial clock rising edges. Bit position 0 is the start bit (logical 1). Positions 1 and 2 are pads (logical 0). Positions 3 to 14 carry LED 1 to LED 12, taken from vector bits 0 to 11. Positions 15 and 16 are trailing pads (logical 0).
- R5: When `inv_mode` is 0, each bit goes onto the line at its logical level. When `inv_mode` is 1, every bit is inverted, so an LED that is on is sent low and the trailing pads are sent high.
- R6: When `fiber_sel` is 1, the LED bits come from `fiber_leds`. When it is 0, they come from `copper_leds`.
- R7: `copper_leds`, `fiber_leds`, `fiber_sel` and `inv_mode` are sampled once, at the start of each frame. Changes made to them while a frame is being shifted do not alter that frame.
- R8: After the last bit, `led_latch` is high for exactly one serial period (2*`HALF_DIV` clocks). During that time `led_sclk` and `led_sdata` are low.
- R9: From the falling edge of `led_latch` to the first `led_sclk` rising edge of the next frame there are exactly (`idle_gap`+1)*2*`HALF_DIV` + `HALF_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_en | input | 1 | Software enable; 0 holds the block idle |
| inv_mode | input | 1 | 1 selects active-low (inverted) line polarity |
| fiber_sel | input | 1 | 1 sends the fiber LED vector, 0 the copper vector |
| idle_gap | input | GAP_W | Extra idle serial periods between frames |
| copper_leds | input | LED_N | Decoded LED states for copper media, bit 0 = LED 1 |
| fiber_leds | input | LED_N | Decoded LED states for fiber media, bit 0 = LED 1 |
| led_sclk | output | 1 | Serial clock to the shift register chain |
| led_sdata | output | 1 | Serial data to the chain |
| led_latch | output | 1 | Parallel-load strobe for the chain |

## Verification
The bench changes every sampled input during each frame. A design that captured its inputs late would then send mixed or wrong LED bits, and one that ignored the capture rule would mix the two media vectors. Frames are sent with zero, small and larger idle gaps and in both polarities. This exposes off-by-one gap counters, data bits inverted in the wrong mode, and pads left uninverted. The bench also drops the enable in the middle of a frame. A design that finished the frame anyway or left a pin high would show it there, and a design that resumed at a stale bit position would fail the next frame check.

// File: rtl/ledsh_pkg.sv
package ledsh_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_GAP   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_LATCH = 2'd3
  } ls_state_e;
endpackage

// File: rtl/ledsh_divider.sv
// Half-period tick generator for the serial clock.
module ledsh_divider #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic half_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == CW'(HALF_DIV - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign half_tick = run && (cnt == CW'(HALF_DIV - 1));
endmodule

// File: rtl/ledsh_framer.sv
// Builds the logical frame: start, lead pads, LED bits, trailing pads.
module ledsh_framer #(
  parameter int LED_N     = 12,
  parameter int LEAD_PAD  = 2,
  parameter int TRAIL_PAD = 2,
  localparam int FRAME_N  = 1 + LEAD_PAD + LED_N + TRAIL_PAD
) (
  input  logic [LED_N-1:0]   copper_leds,
  input  logic [LED_N-1:0]   fiber_leds,
  input  logic               fiber_sel,
  output logic [FRAME_N-1:0] frame_o
);
  localparam int DATA_LO = 1 + LEAD_PAD;
  localparam int DATA_HI = DATA_LO + LED_N;

  logic [LED_N-1:0] leds_sel;

  assign leds_sel = fiber_sel ? fiber_leds : copper_leds;

  for (genvar i = 0; i < FRAME_N; i++) begin : g_bit
    if (i == 0) begin : g_start
      assign frame_o[i] = 1'b1;
    end else if (i < DATA_LO) begin : g_lead
      assign frame_o[i] = 1'b0;
    end else if (i < DATA_HI) begin : g_data
      assign frame_o[i] = leds_sel[i - DATA_LO];
    end else begin : g_trail
      assign frame_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ledsh_seq.sv
// Frame sequencer: gap, shift, latch; registered pin outputs.
module ledsh_seq
  import ledsh_pkg::*;
#(
  parameter int FRAME_N = 17,
  parameter int GAP_W   = 4,
  localparam int IDX_W  = $clog2(FRAME_N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               half_tick,
  input  logic [FRAME_N-1:0] frame_in,
  input  logic               inv_in,
  input  logic [GAP_W-1:0]   idle_gap,
  output logic               sclk_o,
  output logic               sdata_o,
  output logic               latch_o
);
  ls_state_e          state, n_state;
  logic [IDX_W-1:0]   idx, n_idx;
  logic [GAP_W-1:0]   gcnt, n_gcnt;
  logic               phase, n_phase;
  logic [FRAME_N-1:0] frame_q, n_frame;
  logic               inv_q, n_inv;
  logic               slot_end;
  logic               capture;

  assign slot_end = half_tick && phase;

  always_comb begin
    n_state = state;
    n_idx   = idx;
    n_gcnt  = gcnt;
    capture = 1'b0;
    n_phase = half_tick ? ~phase : phase;
    if (!en) begin
      n_state = ST_OFF;
      n_idx   = '0;
      n_gcnt  = '0;
      n_phase = 1'b0;
    end else begin
      unique case (state)
        ST_OFF: begin
          n_state = ST_GAP;
          n_gcnt  = '0;
        end
        ST_GAP: begin
          if (slot_end) begin
            if (gcnt == idle_gap) begin
              n_state = ST_SHIFT;
              n_idx   = '0;
              capture = 1'b1;
            end else begin
              n_gcnt = gcnt + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (slot_end) begin
            if (idx == IDX_W'(FRAME_N - 1)) begin
              n_state = ST_LATCH;
            end else begin
              n_idx = idx + 1'b1;
            end
          end
        end
        ST_LATCH: begin
          if (slot_end) begin
            n_state = ST_GAP;
            n_gcnt  = '0;
          end
        end
        default: n_state = ST_OFF;
      endcase
    end
    n_frame = capture ? frame_in : frame_q;
    n_inv   = capture ? inv_in : inv_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OFF;
      idx     <= '0;
      gcnt    <= '0;
      phase   <= 1'b0;
      frame_q <= '0;
      inv_q   <= 1'b0;
      sclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      latch_o <= 1'b0;
    end else begin
      state   <= n_state;
      idx     <= n_idx;
      gcnt    <= n_gcnt;
      phase   <= n_phase;
      frame_q <= n_frame;
      inv_q   <= n_inv;
      sclk_o  <= (n_state == ST_SHIFT) && n_phase;
      sdata_o <= (n_state == ST_SHIFT) ? (n_frame[n_idx] ^ n_inv) : 1'b0;
      latch_o <= (n_state == ST_LATCH);
    end
  end
endmodule

// File: rtl/led_chain_driver.sv
module led_chain_driver #(
  parameter int HALF_DIV  = 4,
  parameter int LED_N     = 12,
  parameter int LEAD_PAD  = 2,
  parameter int TRAIL_PAD = 2,
  parameter int GAP_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_en,
  input  logic             inv_mode,
  input  logic             fiber_sel,
  input  logic [GAP_W-1:0] idle_gap,
  input  logic [LED_N-1:0] copper_leds,
  input  logic [LED_N-1:0] fiber_leds,
  output logic             led_sclk,
  output logic             led_sdata,
  output logic             led_latch
);
  localparam int FRAME_N = 1 + LEAD_PAD + LED_N + TRAIL_PAD;

  logic               half_tick;
  logic [FRAME_N-1:0] frame_bits;

  ledsh_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (soft_en),
    .half_tick (half_tick)
  );

  ledsh_framer #(
    .LED_N     (LED_N),
    .LEAD_PAD  (LEAD_PAD),
    .TRAIL_PAD (TRAIL_PAD)
  ) u_frm (
    .copper_leds (copper_leds),
    .fiber_leds  (fiber_leds),
    .fiber_sel   (fiber_sel),
    .frame_o     (frame_bits)
  );

  ledsh_seq #(
    .FRAME_N (FRAME_N),
    .GAP_W   (GAP_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (soft_en),
    .half_tick (half_tick),
    .frame_in  (frame_bits),
    .inv_in    (inv_mode),
    .idle_gap  (idle_gap),
    .sclk_o    (led_sclk),
    .sdata_o   (led_sdata),
    .latch_o   (led_latch)
  );
endmodule

// File: rtl/ledsh_checker.sv
module ledsh_checker #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic soft_en,
  input logic led_sclk,
  input logic led_sdata,
  input logic led_latch
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !led_sclk) hi_cnt <= '0;
    else                  hi_cnt <= hi_cnt + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!led_sclk && !led_sdata && !led_latch));

  // R2
  disable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !soft_en |=> (!led_sclk && !led_sdata && !led_latch));

  // R3
  data_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(led_sdata) |-> !led_sclk);

  // R3
  sclk_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(led_sclk) && $past(soft_en)) |-> (hi_cnt == 16'(HALF_DIV)));

  // R8
  latch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    led_latch |-> (!led_sclk && !led_sdata));
endmodule

bind led_chain_driver ledsh_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .soft_en   (soft_en),
  .led_sclk  (led_sclk),
  .led_sdata (led_sdata),
  .led_latch (led_latch)
);

// File: tb/led_chain_driver_tb.sv
`timescale 1ns/1ps
module led_chain_driver_tb;
  localparam int HD = 4;
  localparam int LN = 12;
  localparam int FB = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          inv = 1'b0;
  logic          fsel = 1'b0;
  logic [3:0]    gap = 4'd0;
  logic [LN-1:0] cop = '0;
  logic [LN-1:0] fib = '0;
  logic          sclk, sdata, latch;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [FB-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  led_chain_driver #(.HALF_DIV(HD)) u_dut (
    .clk(clk), .rst(rst), .soft_en(en), .inv_mode(inv), .fiber_sel(fsel),
    .idle_gap(gap), .copper_leds(cop), .fiber_leds(fib),
    .led_sclk(sclk), .led_sdata(sdata), .led_latch(latch)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] line_of(input logic [LN-1:0] c,
      input logic [LN-1:0] f, input logic s, input logic m);
    logic [FB-1:0] v;
    logic [LN-1:0] d;
    d = s ? f : c;
    v = '0;
    v[0] = 1'b1;
    for (int k = 0; k < LN; k++) v[3 + k] = d[k];
    return v ^ {FB{m}};
  endfunction

  // Drive one frame configuration, then scramble inputs once shifting starts (R7).
  task automatic load_cfg(input logic [LN-1:0] c, input logic [LN-1:0] f,
                          input logic s, input logic m, input logic [3:0] g,
                          input string tag);
    cop = c; fib = f; fsel = s; inv = m; gap = g;
    exp_q.push_back(line_of(c, f, s, m));
    tag_q.push_back(tag);
  endtask

  task automatic scramble();
    @(posedge sclk);
    #1;
    cop = ~cop; fib = ~fib; fsel = ~fsel; inv = ~inv;
  endtask

  task automatic send_frame(input logic [LN-1:0] c, input logic [LN-1:0] f,
                            input logic s, input logic m, input logic [3:0] g,
                            input string tag);
    @(negedge latch);
    #1;
    load_cfg(c, f, s, m, g, tag);
    scramble();
  endtask

  // Scoreboard monitor
  logic [FB-1:0] cap;
  int  nbits = 0, hi_cnt = 0, lat_cnt = 0, gcount = 0;
  bit  meas = 0, lat_bad = 0, p_sclk = 0, p_latch = 0;

  always @(negedge clk) begin
    if (!en || rst) begin
      nbits = 0; meas = 0; hi_cnt = 0; lat_cnt = 0; cap = '0;
    end else begin
      if (meas) gcount++;
      if (sclk && !p_sclk) begin
        if (nbits < FB) cap[nbits] = sdata;
        nbits++;
        if (meas) begin
          chk(gcount == (int'(gap) + 1) * 2 * HD + HD, "R9 gap length",
              gcount, (int'(gap) + 1) * 2 * HD + HD);
          meas = 0;
        end
      end
      if (sclk) hi_cnt++;
      else begin
        if (p_sclk) chk(hi_cnt == HD, "R3 sclk high width", hi_cnt, HD);
        hi_cnt = 0;
      end
      if (latch && !p_latch) begin
        chk(nbits == FB, "R4 bits per frame", nbits, FB);
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected frame", cap, 0);
        else begin
          logic [FB-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cap == e, t, cap, e);
        end
        nbits = 0; lat_cnt = 0; lat_bad = 0;
      end
      if (latch) begin
        lat_cnt++;
        if (sclk || sdata) lat_bad = 1;
      end
      if (!latch && p_latch) begin
        chk(lat_cnt == 2 * HD && !lat_bad, "R8 latch pulse", lat_cnt, 2 * HD);
        meas = 1; gcount = 0;
      end
    end
    p_sclk = sclk; p_latch = latch;
  end

  task automatic expect_quiet(input int cycles, input string req);
    bit bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sclk || sdata || latch) bad = 1;
    end
    chk(!bad, req, {sclk, sdata, latch}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    // R1: quiet while disabled after reset
    expect_quiet(40, "R1 outputs low after reset while disabled");

    @(posedge clk); #1;
    load_cfg(12'hA53, 12'h3C5, 1'b0, 1'b0, 4'd2, "R4 copper frame mode 0");
    en = 1'b1;
    scramble();
    send_frame(12'hA53, 12'h3C5, 1'b1, 1'b0, 4'd0, "R6 fiber select");
    send_frame(12'h0F1, 12'h800, 1'b0, 1'b1, 4'd5, "R5 inverted copper");
    send_frame(12'hFFF, 12'h001, 1'b1, 1'b1, 4'd1, "R5 inverted fiber pads high");
    send_frame(12'h000, 12'hFFF, 1'b0, 1'b0, 4'd3, "R7 sample once zeros");
    send_frame(12'h5A5, 12'hC3C, 1'b1, 1'b0, 4'd0, "R7 sample once fiber");

    // R2: drop enable mid-frame
    @(negedge latch);
    repeat (5) @(posedge sclk);
    @(posedge clk); #1;
    en = 1'b0;
    exp_q.delete(); tag_q.delete();
    @(posedge clk); #1;
    expect_quiet(60, "R2 outputs held low after disable");

    @(posedge clk); #1;
    load_cfg(12'h9E7, 12'h111, 1'b0, 1'b1, 4'd1, "R2 fresh frame after re-enable");
    en = 1'b1;
    scramble();
    send_frame(12'h123, 12'h456, 1'b1, 1'b1, 4'd2, "R6 fiber inverted");
    @(posedge latch);
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R4 all frames observed", exp_q.size(), 0);
    finish_run();
  end
endmodule